// File: doc/BRIEF.md
# Load/Store-Multiple Transfer Sequencer

This block carries out a block transfer between a 32-bit register file and word-addressed memory. One start pulse hands it a 16-bit register list, a base register index together with the base register's current value, and five option flags. The flags are: increment-before-or-after, ascending-or-descending, base writeback, load-or-store, and user-bank access. A version-select input chooses between the two rule sets, called v4 and v5. The block then visits the listed registers from the lowest index to the highest. For each one it issues a single word access, with the address rising by 4 after every accepted beat.

Stores read their data through a same-cycle register read port. Loads write the returned word into the register file in the cycle the beat is accepted. After the last beat the block spends one cycle on the base writeback decision, and signals completion in that same cycle. Loading the program counter (register 15) does three things in the cycle of the load: it raises a flush request, updates the instruction-set state flag in v5, and requests a copy of the saved status into the current status when the user-bank flag is set.

The register file, the memory and the banked-mode logic sit outside. The memory side is a request held until ready, and the register ports are plain enables.

Top module: `multi_xfer_seq`

## Requirements
- R1: A start pulse is taken only while `busy` is low. After reset `busy`, `done` and `mem_req` are low. A start pulse seen while busy has no effect on the transfers or their count.
- R2: In ascending mode the first address is base+4 when `pre_inc` is 1 and base when it is 0. Registers go out in ascending index order, and the address grows by 4 after each accepted beat.
- R3: In descending mode the first address is base−4·N when `pre_inc` is 1 and base−4·N+4 when it is 0, where N is the number of set list bits. The order is still ascending index with +4 steps.
- R4: The updated base is base+4·N when ascending and base−4·N when descending. A store with `wback`=1 writes it to the base register. With `wback`=0 the base register is not written.
- R5: While `mem_req` is high and `mem_ready` is low, the address, the write enable and the write data stay unchanged.
- R6: A store without `user_bank` whose list contains the base register writes a fixed value at the base register's slot. In v5 this is always the old base. In v4 it is the old base when the base is the lowest set bit, and the updated base otherwise.
- R7: A load with `wback`=1 writes the updated base when the base is not in the list. If the base is in the list, v4 never writes it back. v5 writes it back only when the base is the only listed register or is not the highest listed one. Any writeback comes after all loads.
- R8: Storing register 15 writes its read value plus 4.
- R9: Loading register 15 writes the word with bit 0 cleared in v5, or bits 1:0 cleared in v4, and pulses `pc_flush`. In v5 it also pulses `isa_wr_en`, with `isa_val` equal to the loaded bit 0.
- R10: With `user_bank`=1, stores read with `rf_rd_user`=1. Loads without register 15 in the list write with `rf_wr_user`=1. Loads with register 15 pulse `psr_restore` together with `pc_flush`.
- R11: An empty list in v4 transfers register 15 alone. The address is base+4 (pre) or base (post) when ascending, and base−0x40 (pre) or base−0x3C (post) when descending. In v5 an empty list makes no beats. In both versions the base register then receives base±0x40, whatever `wback` is.
- R12: `done` is high for exactly one cycle. That cycle follows the final accepted beat, and any base writeback happens in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| reg_list | input | 16 | Selected registers, bit i = register i |
| base_idx | input | 4 | Base register index |
| base_val | input | 32 | Current base register value |
| pre_inc | input | 1 | 1 = step before access, 0 = after |
| ascend | input | 1 | 1 = ascending, 0 = descending |
| wback | input | 1 | Write the updated base back |
| is_load | input | 1 | 1 = load, 0 = store |
| user_bank | input | 1 | User-bank / status-restore option |
| arch_v5 | input | 1 | 1 = v5 rules, 0 = v4 rules |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| rf_rd_en | output | 1 | Register read request (stores) |
| rf_rd_idx | output | 4 | Register read index |
| rf_rd_user | output | 1 | Read from the user bank |
| rf_rd_data | input | 32 | Register read data, same cycle |
| rf_wr_en | output | 1 | Register write enable |
| rf_wr_idx | output | 4 | Register write index |
| rf_wr_user | output | 1 | Write into the user bank |
| rf_wr_data | output | 32 | Register write data |
| pc_flush | output | 1 | Pipeline flush after a register 15 load |
| isa_wr_en | output | 1 | Update the instruction-set state flag (v5) |
| isa_val | output | 1 | New instruction-set state flag value |
| psr_restore | output | 1 | Copy saved status into current status |

## Verification
The beat that loads register 15 is the busiest cycle. In it the register write, `pc_flush`, `psr_restore` and, in v5, `isa_wr_en` must all fire on the same clock edge. The bench provokes this with a user-bank load whose list holds only register 15. It then judges the result by counting each pulse once, alongside the masked value that lands in register 15. A second coincidence is `done` together with the base write. The bench records whether a register write was seen in the `done` cycle, and checks that a suppressed writeback leaves the loaded value in place.

// File: rtl/multi_xfer_pkg.sv
package multi_xfer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BEAT = 2'd1,
      ST_WB   = 2'd2
   } seq_state_t;

   localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/multi_xfer_plan.sv
module multi_xfer_plan #(
   parameter int unsigned NREG   = 16,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = $clog2(NREG)
) (
   input  logic [NREG-1:0]   reg_list,
   input  logic [IDX_W-1:0]  base_idx,
   input  logic [ADDR_W-1:0] base_val,
   input  logic              pre_inc,
   input  logic              ascend,
   input  logic              arch_v5,
   output logic [NREG-1:0]   eff_list,
   output logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] new_base,
   output logic              list_empty,
   output logic              base_in,
   output logic              base_lowest,
   output logic              base_highest,
   output logic              base_sole
);
   import multi_xfer_pkg::*;

   localparam int unsigned CNT_W = IDX_W + 1;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_eff;
   logic [ADDR_W-1:0] span;
   logic [NREG-1:0]   below;
   logic [NREG-1:0]   above;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < NREG; i++) begin
         cnt = cnt + CNT_W'(reg_list[i]);
      end
   end

   for (genvar gi = 0; gi < NREG; gi++) begin : g_rel
      assign below[gi] = reg_list[gi] && (IDX_W'(gi) < base_idx);
      assign above[gi] = reg_list[gi] && (IDX_W'(gi) > base_idx);
   end

   assign list_empty   = (reg_list == '0);
   assign cnt_eff      = list_empty ? CNT_W'(NREG) : cnt;
   assign span         = ADDR_W'(cnt_eff) * STEP;
   assign eff_list     = list_empty ? (arch_v5 ? '0 : {1'b1, {(NREG-1){1'b0}}}) : reg_list;
   assign start_addr   = ascend ? (base_val + (pre_inc ? STEP : '0))
                                : (base_val - span + (pre_inc ? '0 : STEP));
   assign new_base     = ascend ? (base_val + span) : (base_val - span);
   assign base_in      = reg_list[base_idx];
   assign base_lowest  = ~|below;
   assign base_highest = ~|above;
   assign base_sole    = base_in && (cnt == CNT_W'(1));
endmodule

// File: rtl/multi_xfer_pick.sv
module multi_xfer_pick #(
   parameter int unsigned NREG  = 16,
   parameter int unsigned IDX_W = $clog2(NREG)
) (
   input  logic [NREG-1:0]  list,
   output logic [IDX_W-1:0] idx,
   output logic [NREG-1:0]  onehot
);
   always_comb begin
      idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (list[i]) idx = IDX_W'(i);
      end
   end

   assign onehot = NREG'(1) << idx;
endmodule

// File: rtl/multi_xfer_wbrule.sv
module multi_xfer_wbrule (
   input  logic is_load,
   input  logic wback,
   input  logic list_empty,
   input  logic base_in,
   input  logic base_highest,
   input  logic base_sole,
   input  logic arch_v5,
   output logic do_wb
);
   logic load_keep;

   assign load_keep = !base_in || (arch_v5 && (base_sole || !base_highest));
   assign do_wb     = list_empty || (wback && (!is_load || load_keep));
endmodule

// File: rtl/multi_xfer_seq.sv
module multi_xfer_seq #(
   parameter int unsigned NREG   = 16,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NREG-1:0]   reg_list,
   input  logic [IDX_W-1:0]  base_idx,
   input  logic [ADDR_W-1:0] base_val,
   input  logic              pre_inc,
   input  logic              ascend,
   input  logic              wback,
   input  logic              is_load,
   input  logic              user_bank,
   input  logic              arch_v5,
   output logic              busy,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              rf_rd_en,
   output logic [IDX_W-1:0]  rf_rd_idx,
   output logic              rf_rd_user,
   input  logic [ADDR_W-1:0] rf_rd_data,
   output logic              rf_wr_en,
   output logic [IDX_W-1:0]  rf_wr_idx,
   output logic              rf_wr_user,
   output logic [ADDR_W-1:0] rf_wr_data,
   output logic              pc_flush,
   output logic              isa_wr_en,
   output logic              isa_val,
   output logic              psr_restore
);
   import multi_xfer_pkg::*;

   localparam logic [IDX_W-1:0]  PC_IDX  = IDX_W'(NREG - 1);
   localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] MASK_V5 = ~ADDR_W'(1);
   localparam logic [ADDR_W-1:0] MASK_V4 = ~ADDR_W'(3);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("multi_xfer_seq: NREG must be a power of two of at least 2");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("multi_xfer_seq: ADDR_W too small");
   end
   if (IDX_W != $clog2(NREG)) begin : g_bad_idx
      $error("multi_xfer_seq: IDX_W must equal clog2(NREG)");
   end

   seq_state_t        state_q;
   logic [NREG-1:0]   list_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] old_base_q;
   logic [ADDR_W-1:0] new_base_q;
   logic [IDX_W-1:0]  bidx_q;
   logic              load_q, user_q, v5_q, has_pc_q, base_in_q, base_low_q, do_wb_q;

   logic [NREG-1:0]   p_list;
   logic [ADDR_W-1:0] p_start, p_new;
   logic              p_empty, p_in, p_low, p_high, p_sole, p_wb;
   logic [IDX_W-1:0]  cur_idx;
   logic [NREG-1:0]   cur_oh;
   logic [NREG-1:0]   rest;
   logic              beat, accept, is_pc;
   logic [ADDR_W-1:0] st_val, ld_val;

   multi_xfer_plan #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_plan (
      .reg_list(reg_list), .base_idx(base_idx), .base_val(base_val),
      .pre_inc(pre_inc), .ascend(ascend), .arch_v5(arch_v5),
      .eff_list(p_list), .start_addr(p_start), .new_base(p_new),
      .list_empty(p_empty), .base_in(p_in), .base_lowest(p_low),
      .base_highest(p_high), .base_sole(p_sole)
   );

   multi_xfer_wbrule u_wb (
      .is_load(is_load), .wback(wback), .list_empty(p_empty), .base_in(p_in),
      .base_highest(p_high), .base_sole(p_sole), .arch_v5(arch_v5), .do_wb(p_wb)
   );

   multi_xfer_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
      .list(list_q), .idx(cur_idx), .onehot(cur_oh)
   );

   assign beat   = (state_q == ST_BEAT);
   assign accept = beat && mem_ready;
   assign rest   = list_q & ~cur_oh;
   assign is_pc  = (cur_idx == PC_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         list_q     <= '0;
         addr_q     <= '0;
         old_base_q <= '0;
         new_base_q <= '0;
         bidx_q     <= '0;
         load_q     <= 1'b0;
         user_q     <= 1'b0;
         v5_q       <= 1'b0;
         has_pc_q   <= 1'b0;
         base_in_q  <= 1'b0;
         base_low_q <= 1'b0;
         do_wb_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               list_q     <= p_list;
               addr_q     <= p_start;
               old_base_q <= base_val;
               new_base_q <= p_new;
               bidx_q     <= base_idx;
               load_q     <= is_load;
               user_q     <= user_bank;
               v5_q       <= arch_v5;
               has_pc_q   <= p_list[NREG-1];
               base_in_q  <= p_in;
               base_low_q <= p_low;
               do_wb_q    <= p_wb;
               state_q    <= (p_list == '0) ? ST_WB : ST_BEAT;
            end
            ST_BEAT: if (mem_ready) begin
               list_q <= rest;
               addr_q <= addr_q + STEP;
               if (rest == '0) state_q <= ST_WB;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      if (!user_q && base_in_q && (cur_idx == bidx_q)) begin
         st_val = (v5_q || base_low_q) ? old_base_q : new_base_q;
      end else begin
         st_val = rf_rd_data;
      end
      if (is_pc) st_val = st_val + STEP;
   end

   assign ld_val = is_pc ? (mem_rdata & (v5_q ? MASK_V5 : MASK_V4)) : mem_rdata;

   assign busy        = (state_q != ST_IDLE);
   assign done        = (state_q == ST_WB);
   assign mem_req     = beat;
   assign mem_we      = beat && !load_q;
   assign mem_addr    = addr_q;
   assign mem_wdata   = st_val;
   assign rf_rd_en    = beat && !load_q;
   assign rf_rd_idx   = cur_idx;
   assign rf_rd_user  = user_q;
   assign rf_wr_en    = (accept && load_q) || (done && do_wb_q);
   assign rf_wr_idx   = done ? bidx_q : cur_idx;
   assign rf_wr_user  = accept && load_q && user_q && !has_pc_q;
   assign rf_wr_data  = done ? new_base_q : ld_val;
   assign pc_flush    = accept && load_q && is_pc;
   assign isa_wr_en   = pc_flush && v5_q;
   assign isa_val     = mem_rdata[0];
   assign psr_restore = pc_flush && user_q;
endmodule

// File: rtl/multi_xfer_seq_chk.sv
module multi_xfer_seq_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] mem_wdata,
   input logic              rf_wr_en,
   input logic [IDX_W-1:0]  rf_wr_idx,
   input logic [ADDR_W-1:0] rf_wr_data,
   input logic              pc_flush,
   input logic              psr_restore
);
   // R5
   hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req && mem_ready)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4)));

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy && !mem_req));

   // R9
   flush_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_flush |-> (rf_wr_en && (rf_wr_idx == '1) && !rf_wr_data[0] && mem_ready));

   // R10
   restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psr_restore |-> pc_flush);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !rf_wr_en && !done));
endmodule

bind multi_xfer_seq multi_xfer_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
   .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
   .pc_flush(pc_flush), .psr_restore(psr_restore)
);

// File: tb/sim_multi_xfer_seq.sv
module sim_multi_xfer_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] reg_list = '0;
   logic [3:0]  base_idx = '0;
   logic [31:0] base_val = '0;
   logic        pre_inc = 1'b0, ascend = 1'b0, wback = 1'b0, is_load = 1'b0;
   logic        user_bank = 1'b0, arch_v5 = 1'b0;
   logic        busy, done, mem_req, mem_we, mem_ready;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data;
   logic        rf_rd_en, rf_rd_user, rf_wr_en, rf_wr_user;
   logic [3:0]  rf_rd_idx, rf_wr_idx;
   logic        pc_flush, isa_wr_en, isa_val, psr_restore;

   logic [31:0] regs  [16];
   logic [31:0] uregs [16];
   logic [31:0] mem   [256];
   logic [31:0] b_addr[32];
   logic [31:0] b_data[32];
   int nb, flushes, restores, isa_cnt, done_cnt, wb_at_done, hold_err, rdy_cnt;
   logic isa_last, stall_en, pend;
   logic [31:0] p_addr, p_data;
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   multi_xfer_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .reg_list(reg_list), .base_idx(base_idx),
      .base_val(base_val), .pre_inc(pre_inc), .ascend(ascend), .wback(wback),
      .is_load(is_load), .user_bank(user_bank), .arch_v5(arch_v5), .busy(busy),
      .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .rf_rd_en(rf_rd_en), .rf_rd_idx(rf_rd_idx), .rf_rd_user(rf_rd_user),
      .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
      .rf_wr_user(rf_wr_user), .rf_wr_data(rf_wr_data), .pc_flush(pc_flush),
      .isa_wr_en(isa_wr_en), .isa_val(isa_val), .psr_restore(psr_restore)
   );

   assign mem_ready  = !stall_en || (rdy_cnt == 2);
   assign mem_rdata  = mem[mem_addr[9:2]];
   assign rf_rd_data = rf_rd_user ? uregs[rf_rd_idx] : regs[rf_rd_idx];

   always @(posedge clk) begin
      if (mem_req && mem_ready) begin
         rdy_cnt <= 0;
         if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
         b_addr[nb] <= mem_addr;
         b_data[nb] <= mem_we ? mem_wdata : mem_rdata;
         nb <= nb + 1;
      end else if (mem_req) begin
         rdy_cnt <= rdy_cnt + 1;
      end
      if (rf_wr_en) begin
         if (rf_wr_user) uregs[rf_wr_idx] <= rf_wr_data;
         else regs[rf_wr_idx] <= rf_wr_data;
      end
      if (pc_flush) flushes <= flushes + 1;
      if (psr_restore) restores <= restores + 1;
      if (isa_wr_en) begin isa_cnt <= isa_cnt + 1; isa_last <= isa_val; end
      if (done) done_cnt <= done_cnt + 1;
      if (done && rf_wr_en) wb_at_done <= 1;
      if (pend && (!mem_req || mem_addr != p_addr || mem_wdata != p_data)) hold_err <= hold_err + 1;
      pend   <= mem_req && !mem_ready;
      p_addr <= mem_addr;
      p_data <= mem_wdata;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic clear_logs();
      nb = 0; flushes = 0; restores = 0; isa_cnt = 0; done_cnt = 0; wb_at_done = 0;
      hold_err = 0; rdy_cnt = 0; pend = 1'b0; isa_last = 1'b0;
   endtask

   task automatic launch(input logic ld, input logic [15:0] rl, input logic [3:0] bi,
                         input logic [31:0] bv, input logic pr, input logic up,
                         input logic wb, input logic ub, input logic v5);
      @(negedge clk);
      clear_logs();
      regs[bi] = bv;
      is_load = ld; reg_list = rl; base_idx = bi; base_val = bv; pre_inc = pr;
      ascend = up; wback = wb; user_bank = ub; arch_v5 = v5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic finish_op();
      int guard = 0;
      while (done_cnt == 0 && guard < 500) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      chk("R12 single done pulse", 32'(done_cnt), 32'd1);
      chk("R12 idle after done", {31'd0, busy}, 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 reset busy", {31'd0, busy}, 32'd0);
      chk("R1 reset done", {31'd0, done}, 32'd0);
      chk("R1 reset mem_req", {31'd0, mem_req}, 32'd0);
   endtask

   task automatic t_store_asc_pre();
      for (int i = 0; i < 16; i++) regs[i] = 32'h1000 + 32'(i);
      launch(0, 16'b0000_0000_0010_1010, 4'd13, 32'h100, 1, 1, 1, 0, 1);
      finish_op();
      chk("R2 beat count", 32'(nb), 32'd3);
      chk("R2 first addr", b_addr[0], 32'h104);
      chk("R2 third addr", b_addr[2], 32'h10C);
      chk("R2 data order r1", mem[8'h41], 32'h1001);
      chk("R2 data order r5", mem[8'h43], 32'h1005);
      chk("R4 store writeback", regs[13], 32'h10C);
      chk("R12 writeback in done cycle", 32'(wb_at_done), 32'd1);
   endtask

   task automatic t_load_desc_post_stall();
      for (int i = 0; i < 4; i++) mem[8'h7D + i] = 32'hA000 + 32'(i);
      stall_en = 1'b1;
      launch(1, 16'b0000_0000_1001_0101, 4'd9, 32'h200, 0, 0, 1, 0, 0);
      finish_op();
      stall_en = 1'b0;
      chk("R3 first addr", b_addr[0], 32'h1F4);
      chk("R3 last addr", b_addr[3], 32'h200);
      chk("R3 r0 loaded", regs[0], 32'hA000);
      chk("R3 r7 loaded", regs[7], 32'hA003);
      chk("R4 load writeback", regs[9], 32'h1F0);
      chk("R5 beat held while not ready", 32'(hold_err), 32'd0);
   endtask

   task automatic t_store_base_rules();
      regs[1] = 32'h1111;
      launch(0, 16'b0000_0000_0001_0100, 4'd2, 32'h100, 0, 1, 1, 0, 0);
      finish_op();
      chk("R6 v4 base lowest stores old", mem[8'h40], 32'h100);
      chk("R4 v4 store base wb", regs[2], 32'h108);
      launch(0, 16'b0000_0000_0000_0110, 4'd2, 32'h100, 0, 1, 1, 0, 0);
      finish_op();
      chk("R6 v4 base not lowest stores new", mem[8'h41], 32'h108);
      launch(0, 16'b0000_0000_0000_0110, 4'd2, 32'h100, 0, 1, 1, 0, 1);
      finish_op();
      chk("R6 v5 stores old base", mem[8'h41], 32'h100);
   endtask

   task automatic t_store_pc();
      regs[15] = 32'h8000;
      launch(0, 16'h8000, 4'd6, 32'h100, 0, 1, 0, 0, 0);
      finish_op();
      chk("R8 pc stored plus 4", mem[8'h40], 32'h8004);
      chk("R4 no writeback keeps base", regs[6], 32'h100);
      chk("R4 no write in done cycle", 32'(wb_at_done), 32'd0);
   endtask

   task automatic t_load_pc();
      mem[8'h40] = 32'h1237;
      launch(1, 16'h8000, 4'd6, 32'h100, 0, 1, 0, 0, 0);
      finish_op();
      chk("R9 v4 pc masked", regs[15], 32'h1234);
      chk("R9 v4 flush", 32'(flushes), 32'd1);
      chk("R9 v4 no isa update", 32'(isa_cnt), 32'd0);
      launch(1, 16'h8000, 4'd6, 32'h100, 0, 1, 0, 0, 1);
      finish_op();
      chk("R9 v5 pc masked", regs[15], 32'h1236);
      chk("R9 v5 isa update", 32'(isa_cnt), 32'd1);
      chk("R9 v5 isa value", {31'd0, isa_last}, 32'd1);
   endtask

   task automatic t_load_wb_rules();
      mem[8'h40] = 32'hAAAA; mem[8'h41] = 32'hBBBB;
      launch(1, 16'b0000_0000_0010_1000, 4'd5, 32'h100, 0, 1, 1, 0, 0);
      finish_op();
      chk("R7 v4 base in list no wb", regs[5], 32'hBBBB);
      launch(1, 16'b0000_0000_0010_1000, 4'd3, 32'h100, 0, 1, 1, 0, 1);
      finish_op();
      chk("R7 v5 base not highest wb", regs[3], 32'h108);
      launch(1, 16'b0000_0000_0010_1000, 4'd5, 32'h100, 0, 1, 1, 0, 1);
      finish_op();
      chk("R7 v5 base highest no wb", regs[5], 32'hBBBB);
      launch(1, 16'b0000_0000_0010_0000, 4'd5, 32'h100, 0, 1, 1, 0, 1);
      finish_op();
      chk("R7 v5 sole base wb", regs[5], 32'h104);
   endtask

   task automatic t_user_bank();
      uregs[1] = 32'hC001; uregs[2] = 32'hC002; regs[4] = 32'h1004;
      launch(0, 16'b0000_0000_0000_0110, 4'd8, 32'h100, 0, 1, 0, 1, 1);
      finish_op();
      chk("R10 store reads user r1", mem[8'h40], 32'hC001);
      chk("R10 store reads user r2", mem[8'h41], 32'hC002);
      mem[8'h40] = 32'h4444;
      launch(1, 16'b0000_0000_0001_0000, 4'd8, 32'h100, 0, 1, 0, 1, 1);
      finish_op();
      chk("R10 load to user r4", uregs[4], 32'h4444);
      chk("R10 current r4 untouched", regs[4], 32'h1004);
      mem[8'h40] = 32'h5001;
      launch(1, 16'h8000, 4'd8, 32'h100, 0, 1, 0, 1, 1);
      finish_op();
      chk("R10 status restore", 32'(restores), 32'd1);
      chk("R10 flush with restore", 32'(flushes), 32'd1);
      chk("R10 pc in current bank", regs[15], 32'h5000);
   endtask

   task automatic t_empty();
      mem[8'h41] = 32'h2003;
      launch(1, 16'h0000, 4'd1, 32'h100, 1, 1, 0, 0, 0);
      finish_op();
      chk("R11 v4 empty one beat", 32'(nb), 32'd1);
      chk("R11 v4 empty asc pre addr", b_addr[0], 32'h104);
      chk("R11 v4 empty loads pc", regs[15], 32'h2000);
      chk("R11 v4 empty base up", regs[1], 32'h140);
      regs[15] = 32'h3000;
      launch(0, 16'h0000, 4'd2, 32'h200, 0, 0, 0, 0, 0);
      finish_op();
      chk("R11 v4 empty desc post addr", b_addr[0], 32'h1C4);
      chk("R11 v4 empty stores pc+4", b_data[0], 32'h3004);
      chk("R11 v4 empty base down", regs[2], 32'h1C0);
      launch(1, 16'h0000, 4'd3, 32'h100, 0, 1, 0, 0, 1);
      finish_op();
      chk("R11 v5 empty no beats", 32'(nb), 32'd0);
      chk("R11 v5 empty base up", regs[3], 32'h140);
   endtask

   task automatic t_busy_start();
      regs[1] = 32'h77; regs[2] = 32'h88;
      stall_en = 1'b1;
      launch(0, 16'b0000_0000_0000_0110, 4'd8, 32'h100, 0, 1, 0, 0, 0);
      reg_list = 16'hFFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      finish_op();
      stall_en = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 start while busy ignored beats", 32'(nb), 32'd2);
      chk("R1 start while busy stays idle", {31'd0, busy}, 32'd0);
      chk("R1 only one done", 32'(done_cnt), 32'd1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int i = 0; i < 16; i++) begin regs[i] = '0; uregs[i] = '0; end
      stall_en = 1'b0;
      clear_logs();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_store_asc_pre();
      t_load_desc_post_stall();
      t_store_base_rules();
      t_store_pc();
      t_load_pc();
      t_load_wb_rules();
      t_user_bank();
      t_empty();
      t_busy_start();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule